// File: doc/BRIEF.md
# Indirect Pointer Address Generator

This block works out the memory address for indirect loads and stores that use a 16-bit pointer held in two byte registers. It also works out the new pointer value to be written back. The caller supplies the pointer's high and low bytes, an addressing mode and a 6-bit unsigned displacement. For reads from program memory, the caller also supplies an 8-bit page byte. The block returns the address, a pointer write-back strobe with the new pointer split into its two bytes, and, for program-memory reads, a page write-back strobe with the updated page byte. The register file and the memories sit outside the block.

Each request is presented for one cycle with `req_valid_i` high. Its result appears on the outputs after the next rising clock edge, qualified by `vld_o`. In data space the address occupies the low 16 bits and the upper byte is zero. In program space the page byte is placed above the pointer to form a 24-bit address. Post-increment in program space counts across all 24 bits, so a pointer that rolls over carries into the page byte.

Top module: `ptr_agu`

## Requirements
- R1: While `rst_ni` is low, and at the first sample after release, `vld_o`, `ptr_wb_o`, `ext_wb_o`, `err_o` and `addr_o` are all zero.
- R2: The outputs for a request appear one clock edge after it is presented. `vld_o` equals `req_valid_i` delayed by one cycle, and the strobes `ptr_wb_o`, `ext_wb_o` and `err_o` are low when `vld_o` is low.
- R3: Mode 0 (plain): the address is the pointer `{ptr_hi_i, ptr_lo_i}` and `ptr_wb_o` is low.
- R4: Mode 1 (post-increment): the address is the unmodified pointer, `ptr_wb_o` is high, and `{ptr_hi_o, ptr_lo_o}` equals pointer+1.
- R5: Mode 2 (pre-decrement): `{ptr_hi_o, ptr_lo_o}` equals pointer−1, the same value is the address, and `ptr_wb_o` is high.
- R6: Mode 3 (displacement): the address is the pointer plus the zero-extended `disp_i`, and `ptr_wb_o` is low.
- R7: All 16-bit pointer arithmetic wraps: 0xFFFF+1 gives 0x0000, 0x0000−1 gives 0xFFFF, and 0xFFF0+0x3F gives 0x002F.
- R8: With `prog_i` low, `addr_o[23:16]` is zero and `ext_wb_o` is low. With `prog_i` high, the address is `{ext_i, pointer}`.
- R9: With `prog_i` high in mode 1, `{ext_o, ptr_hi_o, ptr_lo_o}` equals the 24-bit address plus 1 (mod 2^24), and both `ptr_wb_o` and `ext_wb_o` are high. A carry out of the pointer therefore increments the page byte.
- R10: With `prog_i` high in mode 2 or 3, `err_o` is high and both `ptr_wb_o` and `ext_wb_o` are low. With `prog_i` low, `err_o` is always low.
- R11: The new pointer is returned split into bytes, with `ptr_hi_o` as bits 15:8 and `ptr_lo_o` as bits 7:0. When no write-back is signalled, the returned pointer and page byte equal the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| prog_i | input | 1 | 1 = paged program-memory read, 0 = data access |
| mode_i | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement |
| ptr_hi_i | input | 8 | Pointer high byte |
| ptr_lo_i | input | 8 | Pointer low byte |
| disp_i | input | 6 | Unsigned displacement |
| ext_i | input | 8 | Program-memory page byte |
| vld_o | output | 1 | Result valid |
| addr_o | output | 24 | Effective address |
| ptr_wb_o | output | 1 | Pointer write-back strobe |
| ptr_hi_o | output | 8 | New pointer high byte |
| ptr_lo_o | output | 8 | New pointer low byte |
| ext_wb_o | output | 1 | Page byte write-back strobe |
| ext_o | output | 8 | New page byte |
| err_o | output | 1 | Illegal mode for program-memory read |

## Verification
Pointer write-back and page-byte carry can happen in the same cycle. A program-space post-increment of pointer 0xFFFF rolls the low 16 bits to zero and bumps the page byte. The bench provokes this with page 0x12 and with page 0xFF. The second case must wrap the whole 24-bit value to zero. Each result is judged by requiring both strobes high together, the address still holding the old 24-bit value, and the returned bytes forming exactly that value plus one.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    MODE_PLAIN    = 2'd0,
    MODE_POST_INC = 2'd1,
    MODE_PRE_DEC  = 2'd2,
    MODE_DISP     = 2'd3
  } agu_mode_e;
endpackage

// File: rtl/agu_data_path.sv
module agu_data_path
  import agu_pkg::*;
#(
  parameter int unsigned PTR_W  = 16,
  parameter int unsigned DISP_W = 6
) (
  input  agu_mode_e          mode_i,
  input  logic [PTR_W-1:0]   ptr_i,
  input  logic [DISP_W-1:0]  disp_i,
  output logic [PTR_W-1:0]   addr_o,
  output logic               wb_o,
  output logic [PTR_W-1:0]   ptr_nxt_o
);
  localparam int unsigned PAD_W = PTR_W - DISP_W;

  logic [PTR_W-1:0] disp_ext;
  logic [PTR_W-1:0] ptr_inc;
  logic [PTR_W-1:0] ptr_dec;

  assign disp_ext = {{PAD_W{1'b0}}, disp_i};
  assign ptr_inc  = ptr_i + PTR_W'(1);
  assign ptr_dec  = ptr_i - PTR_W'(1);

  always_comb begin
    addr_o    = ptr_i;
    wb_o      = 1'b0;
    ptr_nxt_o = ptr_i;
    unique case (mode_i)
      MODE_PLAIN: ;
      MODE_POST_INC: begin
        wb_o      = 1'b1;
        ptr_nxt_o = ptr_inc;
      end
      MODE_PRE_DEC: begin
        // decremented value is both address and write-back
        wb_o      = 1'b1;
        ptr_nxt_o = ptr_dec;
        addr_o    = ptr_dec;
      end
      MODE_DISP: addr_o = ptr_i + disp_ext;
    endcase
  end
endmodule

// File: rtl/agu_prog_path.sv
module agu_prog_path
  import agu_pkg::*;
#(
  parameter int unsigned PTR_W = 16,
  parameter int unsigned EXT_W = 8
) (
  input  agu_mode_e                mode_i,
  input  logic [PTR_W-1:0]         ptr_i,
  input  logic [EXT_W-1:0]         ext_i,
  output logic [PTR_W+EXT_W-1:0]   addr_o,
  output logic                     wb_o,
  output logic [PTR_W-1:0]         ptr_nxt_o,
  output logic [EXT_W-1:0]         ext_nxt_o,
  output logic                     err_o
);
  localparam int unsigned ADDR_W = PTR_W + EXT_W;

  logic [ADDR_W-1:0] full;
  logic [ADDR_W-1:0] full_inc;

  assign full     = {ext_i, ptr_i};
  // one adder spans page and pointer so carry reaches the page byte
  assign full_inc = full + ADDR_W'(1);
  assign addr_o   = full;

  always_comb begin
    wb_o      = 1'b0;
    err_o     = 1'b0;
    ptr_nxt_o = ptr_i;
    ext_nxt_o = ext_i;
    unique case (mode_i)
      MODE_PLAIN: ;
      MODE_POST_INC: begin
        wb_o      = 1'b1;
        ptr_nxt_o = full_inc[PTR_W-1:0];
        ext_nxt_o = full_inc[ADDR_W-1:PTR_W];
      end
      default: err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/agu_out_reg.sv
module agu_out_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
  import agu_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned EXT_W  = 8,
  parameter int unsigned DISP_W = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  input  logic                      prog_i,
  input  logic [1:0]                mode_i,
  input  logic [BYTE_W-1:0]         ptr_hi_i,
  input  logic [BYTE_W-1:0]         ptr_lo_i,
  input  logic [DISP_W-1:0]         disp_i,
  input  logic [EXT_W-1:0]          ext_i,
  output logic                      vld_o,
  output logic [2*BYTE_W+EXT_W-1:0] addr_o,
  output logic                      ptr_wb_o,
  output logic [BYTE_W-1:0]         ptr_hi_o,
  output logic [BYTE_W-1:0]         ptr_lo_o,
  output logic                      ext_wb_o,
  output logic [EXT_W-1:0]          ext_o,
  output logic                      err_o
);
  localparam int unsigned PTR_W  = 2 * BYTE_W;
  localparam int unsigned ADDR_W = PTR_W + EXT_W;
  localparam int unsigned REG_W  = 4 + ADDR_W + PTR_W + EXT_W;

  agu_mode_e         mode;
  logic [PTR_W-1:0]  ptr;

  logic [PTR_W-1:0]  d_addr;
  logic              d_wb;
  logic [PTR_W-1:0]  d_ptr_nxt;

  logic [ADDR_W-1:0] p_addr;
  logic              p_wb;
  logic [PTR_W-1:0]  p_ptr_nxt;
  logic [EXT_W-1:0]  p_ext_nxt;
  logic              p_err;

  logic [ADDR_W-1:0] sel_addr;
  logic              sel_wb;
  logic              sel_ext_wb;
  logic              sel_err;
  logic [PTR_W-1:0]  sel_ptr;
  logic [EXT_W-1:0]  sel_ext;

  logic [REG_W-1:0]  reg_d;
  logic [REG_W-1:0]  reg_q;
  logic [PTR_W-1:0]  ptr_q;

  assign mode = agu_mode_e'(mode_i);
  assign ptr  = {ptr_hi_i, ptr_lo_i};

  agu_data_path #(.PTR_W(PTR_W), .DISP_W(DISP_W)) u_data (
    .mode_i    (mode),
    .ptr_i     (ptr),
    .disp_i    (disp_i),
    .addr_o    (d_addr),
    .wb_o      (d_wb),
    .ptr_nxt_o (d_ptr_nxt)
  );

  agu_prog_path #(.PTR_W(PTR_W), .EXT_W(EXT_W)) u_prog (
    .mode_i    (mode),
    .ptr_i     (ptr),
    .ext_i     (ext_i),
    .addr_o    (p_addr),
    .wb_o      (p_wb),
    .ptr_nxt_o (p_ptr_nxt),
    .ext_nxt_o (p_ext_nxt),
    .err_o     (p_err)
  );

  always_comb begin
    if (prog_i) begin
      sel_addr   = p_addr;
      sel_wb     = p_wb;
      sel_ext_wb = p_wb;
      sel_err    = p_err;
      sel_ptr    = p_ptr_nxt;
      sel_ext    = p_ext_nxt;
    end else begin
      sel_addr   = {{EXT_W{1'b0}}, d_addr};
      sel_wb     = d_wb;
      sel_ext_wb = 1'b0;
      sel_err    = 1'b0;
      sel_ptr    = d_ptr_nxt;
      sel_ext    = ext_i;
    end
  end

  // strobes qualified by request; data fields registered unconditionally
  assign reg_d = {req_valid_i,
                  sel_addr,
                  req_valid_i & sel_wb,
                  sel_ptr,
                  req_valid_i & sel_ext_wb,
                  sel_ext,
                  req_valid_i & sel_err};

  agu_out_reg #(.W(REG_W)) u_oreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (reg_d),
    .q_o    (reg_q)
  );

  assign {vld_o, addr_o, ptr_wb_o, ptr_q, ext_wb_o, ext_o, err_o} = reg_q;
  assign ptr_hi_o = ptr_q[PTR_W-1:BYTE_W];
  assign ptr_lo_o = ptr_q[BYTE_W-1:0];
endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned EXT_W  = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      req_valid_i,
  input logic                      prog_i,
  input logic [1:0]                mode_i,
  input logic                      vld_o,
  input logic [2*BYTE_W+EXT_W-1:0] addr_o,
  input logic                      ptr_wb_o,
  input logic [BYTE_W-1:0]         ptr_hi_o,
  input logic [BYTE_W-1:0]         ptr_lo_o,
  input logic                      ext_wb_o,
  input logic [EXT_W-1:0]          ext_o,
  input logic                      err_o
);
  localparam int unsigned PTR_W  = 2 * BYTE_W;
  localparam int unsigned ADDR_W = PTR_W + EXT_W;

  // R2
  vld_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o == $past(req_valid_i));

  // R2
  strobe_needs_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> !ptr_wb_o && !ext_wb_o && !err_o);

  // R10
  err_blocks_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !ptr_wb_o && !ext_wb_o);

  // R3
  plain_no_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o && $past(mode_i) == 2'd0 |-> !ptr_wb_o);

  // R6
  disp_no_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o && $past(mode_i) == 2'd3 |-> !ptr_wb_o);

  // R4
  postinc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_wb_o && $past(mode_i) == 2'd1 |->
      {ptr_hi_o, ptr_lo_o} == PTR_W'(addr_o[PTR_W-1:0] + PTR_W'(1)));

  // R5
  predec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_wb_o && $past(mode_i) == 2'd2 |-> {ptr_hi_o, ptr_lo_o} == addr_o[PTR_W-1:0]);

  // R9
  ext_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_wb_o |-> ptr_wb_o && {ext_o, ptr_hi_o, ptr_lo_o} == ADDR_W'(addr_o + ADDR_W'(1)));

  // R8
  data_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o && !$past(prog_i) |-> addr_o[ADDR_W-1:PTR_W] == '0 && !ext_wb_o && !err_o);
endmodule

bind ptr_agu agu_chk #(.BYTE_W(BYTE_W), .EXT_W(EXT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .prog_i      (prog_i),
  .mode_i      (mode_i),
  .vld_o       (vld_o),
  .addr_o      (addr_o),
  .ptr_wb_o    (ptr_wb_o),
  .ptr_hi_o    (ptr_hi_o),
  .ptr_lo_o    (ptr_lo_o),
  .ext_wb_o    (ext_wb_o),
  .ext_o       (ext_o),
  .err_o       (err_o)
);

// File: tb/sim_ptr_agu.sv
`timescale 1ns/1ps
module sim_ptr_agu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        prog_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [7:0]  ptr_hi_i = 8'h00;
  logic [7:0]  ptr_lo_i = 8'h00;
  logic [5:0]  disp_i = 6'd0;
  logic [7:0]  ext_i = 8'h00;
  logic        vld_o;
  logic [23:0] addr_o;
  logic        ptr_wb_o;
  logic [7:0]  ptr_hi_o;
  logic [7:0]  ptr_lo_o;
  logic        ext_wb_o;
  logic [7:0]  ext_o;
  logic        err_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  ptr_agu u0 (.*);

  task automatic check(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // one request; expected values derived from the requirements
  task automatic op(input string rq, input bit prog, input int mode, input int p,
                    input int disp, input int ext);
    int e_addr, e_ptr, e_ext, full, n;
    bit e_wb, e_xwb, e_err;
    e_ptr = p; e_ext = ext; e_wb = 0; e_xwb = 0; e_err = 0; e_addr = p;
    if (!prog) begin
      case (mode)
        1: begin e_wb = 1; e_ptr = (p + 1) & 16'hFFFF; end
        2: begin e_wb = 1; e_ptr = (p - 1) & 16'hFFFF; e_addr = e_ptr; end
        3: e_addr = (p + disp) & 16'hFFFF;
        default: ;
      endcase
    end else begin
      full = (ext << 16) | p;
      e_addr = full;
      if (mode == 1) begin
        n = (full + 1) & 24'hFFFFFF;
        e_wb = 1; e_xwb = 1; e_ptr = n & 16'hFFFF; e_ext = n >> 16;
      end else if (mode != 0) e_err = 1;
    end
    @(negedge clk_i);
    req_valid_i = 1'b1; prog_i = prog; mode_i = 2'(mode);
    ptr_hi_i = 8'(p >> 8); ptr_lo_i = 8'(p); disp_i = 6'(disp); ext_i = 8'(ext);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check(rq, "vld", int'(vld_o), 1);
    check(rq, "addr", int'(addr_o), e_addr);
    check(rq, "ptr_wb", int'(ptr_wb_o), int'(e_wb));
    check(rq, "ptr_hi", int'(ptr_hi_o), (e_ptr >> 8) & 8'hFF);
    check(rq, "ptr_lo", int'(ptr_lo_o), e_ptr & 8'hFF);
    check(rq, "ext_wb", int'(ext_wb_o), int'(e_xwb));
    check(rq, "ext", int'(ext_o), e_ext);
    check(rq, "err", int'(err_o), int'(e_err));
  endtask

  task automatic t_reset();
    check("R1", "vld in reset", int'(vld_o), 0);
    check("R1", "addr in reset", int'(addr_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", "vld after release", int'(vld_o), 0);
    check("R1", "strobes after release", int'({ptr_wb_o, ext_wb_o, err_o}), 0);
  endtask

  task automatic t_latency();
    op("R2", 1'b0, 1, 16'h1234, 0, 0);
    @(negedge clk_i);
    check("R2", "vld drops", int'(vld_o), 0);
    check("R2", "strobes drop", int'({ptr_wb_o, ext_wb_o, err_o}), 0);
  endtask

  task automatic t_plain();
    op("R3", 1'b0, 0, 16'hA55A, 5, 8'h77);
    op("R3", 1'b0, 0, 16'h0000, 0, 0);
  endtask

  task automatic t_postinc();
    op("R4", 1'b0, 1, 16'h00FF, 0, 0);
    op("R4", 1'b0, 1, 16'h7FFF, 0, 0);
  endtask

  task automatic t_predec();
    op("R5", 1'b0, 2, 16'h0100, 0, 0);
    op("R5", 1'b0, 2, 16'h8000, 0, 0);
  endtask

  task automatic t_disp();
    op("R6", 1'b0, 3, 16'h1000, 63, 0);
    op("R6", 1'b0, 3, 16'h20FE, 2, 0);
  endtask

  task automatic t_wrap();
    op("R7", 1'b0, 1, 16'hFFFF, 0, 0);
    op("R7", 1'b0, 2, 16'h0000, 0, 0);
    op("R7", 1'b0, 3, 16'hFFF0, 63, 0);
  endtask

  task automatic t_prog();
    op("R8", 1'b1, 0, 16'hBEEF, 0, 8'h3C);
    op("R8", 1'b0, 0, 16'hBEEF, 0, 8'h3C);
  endtask

  task automatic t_prog_carry();
    op("R9", 1'b1, 1, 16'h1234, 0, 8'h05);
    op("R9", 1'b1, 1, 16'hFFFF, 0, 8'h12);
    op("R9", 1'b1, 1, 16'hFFFF, 0, 8'hFF);
  endtask

  task automatic t_prog_illegal();
    op("R10", 1'b1, 2, 16'h4000, 0, 8'h01);
    op("R10", 1'b1, 3, 16'h4000, 9, 8'h01);
  endtask

  task automatic t_split();
    op("R11", 1'b0, 1, 16'h12FF, 0, 0);
    op("R11", 1'b0, 3, 16'hC3A5, 1, 8'h9E);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_plain();
    t_postinc();
    t_predec();
    t_disp();
    t_wrap();
    t_prog();
    t_prog_carry();
    t_prog_illegal();
    t_split();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule